// File: doc/BRIEF.md
# I2C Command Queue Sequencer

This block stores command words for one I2C master in two independent queues (a deep one of 64 words and a short one of 16 words). Software appends 32-bit words to a queue, then commits how many of them are to run, then pulses that queue's start bit. The sequencer walks the committed words from the first one. It decodes a 4-bit opcode in each word and turns write and read commands into single-byte operations for a separate bit-level bus engine.

Bytes returned by read operations are packed least significant byte first into 32-bit words in a small read buffer, which software drains. Completion is signalled by one-cycle event pulses: one per queue for report commands, one for the end of each read command, and one for an engine error. An error or a halt stops the queue at once and empties it. Words with an opcode the block does not handle (wait, sync, external event, lock and the like) are skipped.

Top module: `cqs_cmd_queue`

## Requirements
- R1: Each accepted load stores the word at the position given by that queue's current count and raises the count by one; the count of queue q is visible on `cur_count[q*CNT_W +: CNT_W]`.
- R2: A load to a queue that already holds its full depth (64 for queue 0, 16 for queue 1) is refused: `ld_err` pulses for one cycle in the following cycle and the count stays unchanged.
- R3: Pulsing `start[q]` while idle runs queue q from word 0 through the number of words last committed with `cm_valid`; when those words are done, `busy` falls and the current and committed counts of that queue return to zero, even if more words were loaded.
- R4: The opcode is bits 3:0 of a word. Opcode 1 takes a 7-bit target address from bits 10:4, which is presented on `eng_addr` for every later byte operation.
- R5: Opcode 9 is a write of N bytes, N from bits 7:4. The data bytes follow the opcode byte in little-endian order within the word and continue into the following words; each byte becomes one engine write (`eng_kind` 0) in order, with `eng_first` on the first and `eng_last` on the last, and the next command starts on the next word.
- R6: Opcode 10 is a read of N bytes, N from bits 7:4: N engine reads (`eng_kind` 1) are issued; the returned bytes are packed least significant byte first, and the read buffer level grows by N/4+1 words (integer division), the final word zero-filled in unused bytes.
- R7: `ev_rd_done` pulses once for every read command, including a read of zero bytes.
- R8: Opcode 8 with bit 8 set pulses `ev_report[q]` of the running queue; with bit 8 clear it produces no event.
- R9: Any other opcode is skipped: it advances by one word and starts no engine operation.
- R10: An engine error (`eng_err` with `eng_done`) pulses `ev_error`, ends the run with no further word executed, and empties the queue.
- R11: `halt` stops any run in the next cycle, empties both queues and the read buffer.
- R12: Loads and commits aimed at the queue that is running are refused (`ld_err` pulses for a refused load).
- R13: `eng_req` stays high with kind, data, first and last flags stable until `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Append `ld_word` to queue `ld_sel` |
| ld_sel | input | 1 | Queue chosen for a load |
| ld_word | input | 32 | Command word to append |
| ld_err | output | 1 | One-cycle pulse: last load was refused |
| cm_valid | input | 1 | Commit `cm_count` as run length of queue `cm_sel` |
| cm_sel | input | 1 | Queue chosen for a commit |
| cm_count | input | CNT_W (7) | Number of words to run |
| cur_count | output | 2*CNT_W (14) | Current word count of each queue, queue 0 in the low field |
| start | input | 2 | Bit q starts queue q |
| halt | input | 1 | Abort and empty everything |
| busy | output | 1 | A queue is running |
| eng_req | output | 1 | Byte operation request to the bus engine |
| eng_kind | output | 1 | 0 write, 1 read |
| eng_first | output | 1 | First byte of a command |
| eng_last | output | 1 | Last byte of a command |
| eng_addr | output | 7 | Target address |
| eng_wdata | output | 8 | Byte to write |
| eng_done | input | 1 | Engine finished the requested byte |
| eng_err | input | 1 | Engine failure, valid with `eng_done` |
| eng_rdata | input | 8 | Byte read, valid with `eng_done` |
| rb_pop | input | 1 | Remove the head word of the read buffer |
| rb_data | output | 32 | Head word of the read buffer |
| rb_level | output | $clog2(RB_DEPTH+1) (4) | Words held in the read buffer |
| ev_report | output | 2 | Report event per queue |
| ev_rd_done | output | 1 | A read command completed |
| ev_error | output | 1 | Engine error ended the run |

## Verification
The assertions take for granted that the bus engine raises `eng_done` only while a request is pending and that software drains the read buffer before it can fill, so a push never meets a full buffer. The stimulus keeps to this by limiting reads to at most 15 bytes (four words) and popping the buffer after every read test. Command words are assumed well formed, with a write's data words inside the committed count, and every queue built by the bench respects that; the engine model answers each request after a fixed latency and can inject a single error at a chosen operation.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

   localparam int WORD_W = 32;
   localparam int ADDR_W = 7;

   // opcode values decoded from bits 3:0
   localparam logic [3:0] OPC_SETP   = 4'd1;
   localparam logic [3:0] OPC_REPORT = 4'd8;
   localparam logic [3:0] OPC_WRITE  = 4'd9;
   localparam logic [3:0] OPC_READ   = 4'd10;

   localparam logic ENG_WR = 1'b0;
   localparam logic ENG_RD = 1'b1;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_DECODE,
      SQ_WBYTE,
      SQ_RBYTE,
      SQ_RFLUSH
   } seq_st_e;

endpackage

// File: rtl/cqs_queue_store.sv
module cqs_queue_store #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 7,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [31:0]      ld_word,
   input  logic             cm_en,
   input  logic [CNT_W-1:0] cm_val,
   input  logic             clr,
   input  logic             lock,
   input  logic [AW-1:0]    rd_idx,
   output logic [31:0]      rd_word,
   output logic [CNT_W-1:0] cur_cnt,
   output logic [CNT_W-1:0] exe_cnt,
   output logic             ld_rej
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cqs_queue_store: DEPTH must be a power of two of at least 2");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
      $error("cqs_queue_store: CNT_W too narrow for DEPTH");
   end

   logic [31:0] mem [DEPTH];
   logic        full;
   logic        ld_ok;

   assign full    = (cur_cnt == CNT_W'(DEPTH));
   assign ld_ok   = ld_en && !full && !lock && !clr;
   assign ld_rej  = ld_en && !ld_ok;
   assign rd_word = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (ld_ok) mem[cur_cnt[AW-1:0]] <= ld_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_cnt <= '0;
         exe_cnt <= '0;
      end else if (clr) begin
         cur_cnt <= '0;
         exe_cnt <= '0;
      end else begin
         if (ld_ok) cur_cnt <= cur_cnt + CNT_W'(1);
         if (cm_en && !lock) exe_cnt <= cm_val;
      end
   end

   // full queue refuses the word and keeps its count
   assert_full_reject_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && full && !clr) |=> $stable(cur_cnt));

endmodule

// File: rtl/cqs_rd_packer.sv
module cqs_rd_packer #(
   parameter int RB_DEPTH = 8,
   localparam int PW = $clog2(RB_DEPTH),
   localparam int LW = $clog2(RB_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_all,
   input  logic          drop,
   input  logic          byte_en,
   input  logic [7:0]    byte_val,
   input  logic          flush,
   input  logic          pop,
   output logic [31:0]   rd_data,
   output logic [LW-1:0] level
);

   if (RB_DEPTH < 4 || (RB_DEPTH & (RB_DEPTH - 1)) != 0) begin : g_bad_rb
      $error("cqs_rd_packer: RB_DEPTH must be a power of two of at least 4");
   end

   logic [31:0]   part;
   logic [1:0]    lane;
   logic [31:0]   fifo [RB_DEPTH];
   logic [PW-1:0] hd, tl;
   logic          push, do_push, do_pop;
   logic [31:0]   push_word;

   assign push      = (byte_en && lane == 2'd3) || flush;
   assign push_word = flush ? part : {byte_val, part[23:0]};
   assign do_push   = push && !clr_all && (level != LW'(RB_DEPTH));
   assign do_pop    = pop && !clr_all && (level != '0);
   assign rd_data   = fifo[hd];

   always_ff @(posedge clk) begin
      if (do_push) fifo[tl] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part <= '0;
         lane <= '0;
      end else if (clr_all || drop || flush) begin
         part <= '0;
         lane <= '0;
      end else if (byte_en) begin
         if (lane == 2'd3) begin
            part <= '0;
            lane <= '0;
         end else begin
            part[int'(lane)*8 +: 8] <= byte_val;
            lane <= lane + 2'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hd    <= '0;
         tl    <= '0;
         level <= '0;
      end else if (clr_all) begin
         hd    <= '0;
         tl    <= '0;
         level <= '0;
      end else begin
         if (do_push) tl <= tl + PW'(1);
         if (do_pop)  hd <= hd + PW'(1);
         if (do_push && !do_pop)      level <= level + LW'(1);
         else if (do_pop && !do_push) level <= level - LW'(1);
      end
   end

   // software is expected to drain before the buffer fills
   assert_no_overflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr_all) |-> (level != LW'(RB_DEPTH)));

endmodule

// File: rtl/cqs_sequencer.sv
module cqs_sequencer
   import cqs_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            start,
   input  logic                  halt,
   input  logic [1:0][CNT_W-1:0] exe_cnt,
   input  logic [31:0]           word,
   output logic [CNT_W-1:0]      rd_ptr,
   output logic                  aq,
   output logic [1:0]            clr_q,
   output logic                  busy,
   output logic                  eng_req,
   output logic                  eng_kind,
   output logic                  eng_first,
   output logic                  eng_last,
   output logic [ADDR_W-1:0]     eng_addr,
   output logic [7:0]            eng_wdata,
   input  logic                  eng_done,
   input  logic                  eng_err,
   input  logic [7:0]            eng_rdata,
   output logic                  pk_byte_en,
   output logic [7:0]            pk_byte,
   output logic                  pk_flush,
   output logic                  pk_drop,
   output logic                  pk_clr_all,
   output logic [1:0]            ev_report,
   output logic                  ev_rd_done,
   output logic                  ev_error
);

   seq_st_e           st;
   logic [CNT_W-1:0]  ptr, lim;
   logic [ADDR_W-1:0] addr;
   logic [3:0]        len, bcnt;
   logic [1:0]        lane;
   logic [3:0]        opc;
   logic [3:0]        nfield;
   logic              last_b, abort, finish;

   assign opc    = word[3:0];
   assign nfield = word[7:4];
   assign last_b = (bcnt == len - 4'd1);
   assign rd_ptr = ptr;
   assign busy   = (st != SQ_IDLE);

   assign eng_req   = (st == SQ_WBYTE) || (st == SQ_RBYTE);
   assign eng_kind  = (st == SQ_RBYTE) ? ENG_RD : ENG_WR;
   assign eng_first = (bcnt == 4'd0);
   assign eng_last  = last_b;
   assign eng_addr  = addr;
   assign eng_wdata = (st == SQ_WBYTE) ? word[int'(lane)*8 +: 8] : 8'h00;

   assign abort      = !halt && eng_req && eng_done && eng_err;
   assign finish     = !halt && (st == SQ_DECODE) && (ptr >= lim);
   assign pk_byte_en = !halt && (st == SQ_RBYTE) && eng_done && !eng_err;
   assign pk_byte    = eng_rdata;
   assign pk_flush   = !halt && (st == SQ_RFLUSH);
   assign pk_drop    = abort;
   assign pk_clr_all = halt;

   always_comb begin
      clr_q = 2'b00;
      if (halt)                 clr_q = 2'b11;
      else if (finish || abort) clr_q[aq] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         aq         <= 1'b0;
         ptr        <= '0;
         lim        <= '0;
         addr       <= '0;
         len        <= '0;
         bcnt       <= '0;
         lane       <= '0;
         ev_report  <= '0;
         ev_rd_done <= 1'b0;
         ev_error   <= 1'b0;
      end else begin
         ev_report  <= '0;
         ev_rd_done <= 1'b0;
         ev_error   <= 1'b0;
         if (halt) begin
            st <= SQ_IDLE;
         end else begin
            unique case (st)
               SQ_IDLE: begin
                  if (|start) begin
                     aq  <= !start[0];
                     ptr <= '0;
                     lim <= exe_cnt[!start[0]];
                     st  <= SQ_DECODE;
                  end
               end
               SQ_DECODE: begin
                  if (ptr >= lim) begin
                     st <= SQ_IDLE;
                  end else begin
                     unique case (opc)
                        OPC_SETP: begin
                           addr <= word[10:4];
                           ptr  <= ptr + CNT_W'(1);
                        end
                        OPC_REPORT: begin
                           if (word[8]) ev_report[aq] <= 1'b1;
                           ptr <= ptr + CNT_W'(1);
                        end
                        OPC_WRITE: begin
                           len  <= nfield;
                           bcnt <= '0;
                           lane <= 2'd1;
                           if (nfield == 4'd0) ptr <= ptr + CNT_W'(1);
                           else                st  <= SQ_WBYTE;
                        end
                        OPC_READ: begin
                           len  <= nfield;
                           bcnt <= '0;
                           ptr  <= ptr + CNT_W'(1);
                           st   <= (nfield == 4'd0) ? SQ_RFLUSH : SQ_RBYTE;
                        end
                        default: ptr <= ptr + CNT_W'(1);
                     endcase
                  end
               end
               SQ_WBYTE: begin
                  if (eng_done) begin
                     if (eng_err) begin
                        ev_error <= 1'b1;
                        st       <= SQ_IDLE;
                     end else begin
                        bcnt <= bcnt + 4'd1;
                        lane <= lane + 2'd1;
                        if (last_b || lane == 2'd3) ptr <= ptr + CNT_W'(1);
                        if (last_b) st <= SQ_DECODE;
                     end
                  end
               end
               SQ_RBYTE: begin
                  if (eng_done) begin
                     if (eng_err) begin
                        ev_error <= 1'b1;
                        st       <= SQ_IDLE;
                     end else begin
                        bcnt <= bcnt + 4'd1;
                        if (last_b) st <= SQ_RFLUSH;
                     end
                  end
               end
               SQ_RFLUSH: begin
                  ev_rd_done <= 1'b1;
                  st         <= SQ_DECODE;
               end
               default: st <= SQ_IDLE;
            endcase
         end
      end
   end

   assert_req_hold_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done && !halt) |=>
         (eng_req && $stable(eng_kind) && $stable(eng_wdata) &&
          $stable(eng_first) && $stable(eng_last)));

   assert_report_onehot_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ev_report));

   assert_halt_stops_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !busy);

   assert_err_abort_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && ev_error));

   assert_flush_event_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      pk_flush |=> ev_rd_done);

endmodule

// File: rtl/cqs_cmd_queue.sv
module cqs_cmd_queue
   import cqs_pkg::*;
#(
   parameter int Q0_DEPTH = 64,
   parameter int Q1_DEPTH = 16,
   parameter int RB_DEPTH = 8,
   localparam int MAX_D   = (Q0_DEPTH > Q1_DEPTH) ? Q0_DEPTH : Q1_DEPTH,
   localparam int CNT_W   = $clog2(MAX_D + 1),
   localparam int LW      = $clog2(RB_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_valid,
   input  logic                 ld_sel,
   input  logic [31:0]          ld_word,
   output logic                 ld_err,
   input  logic                 cm_valid,
   input  logic                 cm_sel,
   input  logic [CNT_W-1:0]     cm_count,
   output logic [2*CNT_W-1:0]   cur_count,
   input  logic [1:0]           start,
   input  logic                 halt,
   output logic                 busy,
   output logic                 eng_req,
   output logic                 eng_kind,
   output logic                 eng_first,
   output logic                 eng_last,
   output logic [ADDR_W-1:0]    eng_addr,
   output logic [7:0]           eng_wdata,
   input  logic                 eng_done,
   input  logic                 eng_err,
   input  logic [7:0]           eng_rdata,
   input  logic                 rb_pop,
   output logic [31:0]          rb_data,
   output logic [LW-1:0]        rb_level,
   output logic [1:0]           ev_report,
   output logic                 ev_rd_done,
   output logic                 ev_error
);

   logic [1:0][31:0]      qword;
   logic [1:0][CNT_W-1:0] qexe;
   logic [1:0]            qrej;
   logic [1:0]            clr_q;
   logic [CNT_W-1:0]      rd_ptr;
   logic                  aq;
   logic                  pk_byte_en, pk_flush, pk_drop, pk_clr_all;
   logic [7:0]            pk_byte;

   for (genvar q = 0; q < 2; q++) begin : g_q
      localparam int D   = (q == 0) ? Q0_DEPTH : Q1_DEPTH;
      localparam int QAW = $clog2(D);
      logic lock;
      assign lock = busy && (aq == 1'(q));
      cqs_queue_store #(.DEPTH(D), .CNT_W(CNT_W)) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_en   (ld_valid && (ld_sel == 1'(q))),
         .ld_word (ld_word),
         .cm_en   (cm_valid && (cm_sel == 1'(q))),
         .cm_val  (cm_count),
         .clr     (clr_q[q]),
         .lock    (lock),
         .rd_idx  (rd_ptr[QAW-1:0]),
         .rd_word (qword[q]),
         .cur_cnt (cur_count[q*CNT_W +: CNT_W]),
         .exe_cnt (qexe[q]),
         .ld_rej  (qrej[q])
      );
   end

   cqs_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .halt       (halt),
      .exe_cnt    (qexe),
      .word       (qword[aq]),
      .rd_ptr     (rd_ptr),
      .aq         (aq),
      .clr_q      (clr_q),
      .busy       (busy),
      .eng_req    (eng_req),
      .eng_kind   (eng_kind),
      .eng_first  (eng_first),
      .eng_last   (eng_last),
      .eng_addr   (eng_addr),
      .eng_wdata  (eng_wdata),
      .eng_done   (eng_done),
      .eng_err    (eng_err),
      .eng_rdata  (eng_rdata),
      .pk_byte_en (pk_byte_en),
      .pk_byte    (pk_byte),
      .pk_flush   (pk_flush),
      .pk_drop    (pk_drop),
      .pk_clr_all (pk_clr_all),
      .ev_report  (ev_report),
      .ev_rd_done (ev_rd_done),
      .ev_error   (ev_error)
   );

   cqs_rd_packer #(.RB_DEPTH(RB_DEPTH)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (pk_clr_all),
      .drop     (pk_drop),
      .byte_en  (pk_byte_en),
      .byte_val (pk_byte),
      .flush    (pk_flush),
      .pop      (rb_pop),
      .rd_data  (rb_data),
      .level    (rb_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ld_err <= 1'b0;
      else        ld_err <= |qrej;
   end

   // a load aimed at the running queue never changes its count
   assert_busy_lock_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && busy && (ld_sel == aq) && !halt && clr_q == 2'b00) |=> ld_err);

endmodule

// File: tb/sim_cqs_cmd_queue.sv
module sim_cqs_cmd_queue;

   localparam int CLK_PERIOD = 10;
   localparam int CW  = 7;
   localparam int LAT = 2;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          rst_n;
   logic          ld_valid, ld_sel, ld_err;
   logic [31:0]   ld_word;
   logic          cm_valid, cm_sel;
   logic [CW-1:0] cm_count;
   logic [2*CW-1:0] cur_count;
   logic [1:0]    start;
   logic          halt, busy;
   logic          eng_req, eng_kind, eng_first, eng_last;
   logic [6:0]    eng_addr;
   logic [7:0]    eng_wdata;
   logic          eng_done, eng_err;
   logic [7:0]    eng_rdata;
   logic          rb_pop;
   logic [31:0]   rb_data;
   logic [3:0]    rb_level;
   logic [1:0]    ev_report;
   logic          ev_rd_done, ev_error;

   cqs_cmd_queue u0 (.*);

   int n_cmp = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // engine model and operation log
   int nlog = 0, nrd = 0, lat = 0, err_at = -1;
   logic       lg_kind  [1024];
   logic       lg_first [1024];
   logic       lg_last  [1024];
   logic [7:0] lg_data  [1024];
   logic [6:0] lg_addr  [1024];

   function automatic logic [7:0] rbv(input int k);
      return 8'((k * 37 + 5) % 256);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         eng_done <= 1'b0; eng_err <= 1'b0; eng_rdata <= 8'h00; lat <= 0;
      end else begin
         eng_done <= 1'b0;
         eng_err  <= 1'b0;
         if (eng_req && !eng_done) begin
            if (lat == LAT) begin
               lat <= 0;
               eng_done  <= 1'b1;
               eng_err   <= (nlog == err_at);
               eng_rdata <= rbv(nrd);
               lg_kind[nlog]  <= eng_kind;
               lg_first[nlog] <= eng_first;
               lg_last[nlog]  <= eng_last;
               lg_data[nlog]  <= eng_wdata;
               lg_addr[nlog]  <= eng_addr;
               nlog <= nlog + 1;
               if (eng_kind) nrd <= nrd + 1;
            end else lat <= lat + 1;
         end else lat <= 0;
      end
   end

   // event counters and request-hold monitor
   int n_rep0 = 0, n_rep1 = 0, n_rdd = 0, n_err = 0, n_lerr = 0, n_hold = 0;
   logic p_req = 0, p_done = 0, p_halt = 0, p_kind = 0, p_first = 0, p_last = 0;
   logic [7:0] p_wd = 0;
   always @(posedge clk) begin
      if (rst_n) begin
         if (ev_report[0]) n_rep0++;
         if (ev_report[1]) n_rep1++;
         if (ev_rd_done) n_rdd++;
         if (ev_error) n_err++;
         if (ld_err) n_lerr++;
         if (p_req && !p_done && !p_halt &&
             (!eng_req || eng_kind != p_kind || eng_wdata != p_wd ||
              eng_first != p_first || eng_last != p_last)) n_hold++;
      end
      p_req <= eng_req; p_done <= eng_done; p_halt <= halt; p_kind <= eng_kind;
      p_wd <= eng_wdata; p_first <= eng_first; p_last <= eng_last;
   end

   function automatic int cc(input int q);
      return int'(cur_count[q*CW +: CW]);
   endfunction

   task automatic load(input bit q, input logic [31:0] w);
      ld_valid = 1'b1; ld_sel = q; ld_word = w;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic commit(input bit q, input int n);
      cm_valid = 1'b1; cm_sel = q; cm_count = CW'(n);
      @(negedge clk);
      cm_valid = 1'b0;
   endtask

   task automatic go(input bit q);
      start = q ? 2'b10 : 2'b01;
      @(negedge clk);
      start = 2'b00;
   endtask

   task automatic wait_idle(input string req);
      int guard = 0;
      while (busy && guard < 3000) begin @(negedge clk); guard++; end
      if (guard >= 3000) chk(1'b0, req, 1, 0);
      @(negedge clk);
   endtask

   task automatic do_halt();
      halt = 1'b1;
      @(negedge clk);
      halt = 1'b0;
   endtask

   // write sweep on queue 0
   task automatic run_write(input int n);
      logic [7:0] b [16];
      int nw, base, r0, ok_d, ok_f;
      logic [6:0] a;
      a = 7'(7'h20 + n);
      b[0] = {4'(n), 4'h9};
      for (int k = 1; k < 16; k++) b[k] = (k <= n) ? 8'((k * 29 + n * 3 + 1) % 256) : 8'h00;
      nw = (n + 4) / 4;
      base = nlog; r0 = n_rep0;
      load(1'b0, {21'd0, a, 4'h1});
      for (int j = 0; j < nw; j++) load(1'b0, {b[4*j+3], b[4*j+2], b[4*j+1], b[4*j]});
      load(1'b0, 32'h0000_0108);
      commit(1'b0, nw + 2);
      go(1'b0);
      wait_idle("R5");
      chk(nlog - base == n, "R5 byte count", nlog - base, n);
      ok_d = 1; ok_f = 1;
      for (int i = 0; i < n; i++) begin
         if (lg_kind[base+i] != 1'b0 || lg_data[base+i] != b[i+1]) ok_d = 0;
         if (lg_first[base+i] != (i == 0) || lg_last[base+i] != (i == n - 1)) ok_f = 0;
      end
      chk(ok_d == 1, "R5 write data order", ok_d, 1);
      chk(ok_f == 1, "R5 first/last flags", ok_f, 1);
      if (n > 0) chk(lg_addr[base] == a, "R4 address", lg_addr[base], a);
      chk(n_rep0 - r0 == 1, "R8 report with bit 8", n_rep0 - r0, 1);
      chk(cc(0) == 0, "R3 counts cleared after run", cc(0), 0);
   endtask

   // read sweep on queue 1
   task automatic run_read(input int n);
      int base, rb0, r1, d0, lvl_exp, ok_w;
      logic [31:0] ew, got;
      base = nlog; rb0 = nrd; r1 = n_rep1; d0 = n_rdd;
      load(1'b1, 32'h0000_0151);
      load(1'b1, {24'd0, 4'(n), 4'hA});
      load(1'b1, 32'h0000_0008);
      commit(1'b1, 3);
      go(1'b1);
      wait_idle("R6");
      chk(nlog - base == n, "R6 read op count", nlog - base, n);
      ok_w = 1;
      for (int i = 0; i < n; i++) if (lg_kind[base+i] != 1'b1) ok_w = 0;
      chk(ok_w == 1, "R6 read kind", ok_w, 1);
      chk(n_rdd - d0 == 1, "R7 read done event", n_rdd - d0, 1);
      chk(n_rep1 - r1 == 0, "R8 report without bit 8", n_rep1 - r1, 0);
      lvl_exp = n / 4 + 1;
      chk(int'(rb_level) == lvl_exp, "R6 buffer level", rb_level, lvl_exp);
      ok_w = 1; got = 0; ew = 0;
      for (int j = 0; j < lvl_exp; j++) begin
         ew = 0;
         for (int i = 0; i < 4; i++) if (4*j + i < n) ew[8*i +: 8] = rbv(rb0 + 4*j + i);
         if (rb_data != ew && ok_w == 1) begin ok_w = 0; got = rb_data; end
         rb_pop = 1'b1; @(negedge clk); rb_pop = 1'b0;
      end
      chk(ok_w == 1, "R6 packed read words", got, ew);
   endtask

   initial begin
      int b0, r0, l0, e0;
      rst_n = 1'b0; ld_valid = 0; ld_sel = 0; ld_word = 0; cm_valid = 0; cm_sel = 0;
      cm_count = 0; start = 0; halt = 0; rb_pop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk(!busy && !eng_req && rb_level == 0 && cur_count == 0, "reset state (R1)",
          {busy, eng_req, rb_level}, 0);

      // R1 and R2: count growth and full refusal on queue 1
      for (int k = 0; k < 3; k++) load(1'b1, 32'h0000_0000);
      chk(cc(1) == 3, "R1 count after three loads", cc(1), 3);
      for (int k = 3; k < 16; k++) load(1'b1, 32'h0000_0000);
      chk(cc(1) == 16, "R1 count at full depth", cc(1), 16);
      l0 = n_lerr;
      load(1'b1, 32'h0000_0000);
      @(negedge clk);
      chk(n_lerr - l0 == 1, "R2 load refused when full", n_lerr - l0, 1);
      chk(cc(1) == 16, "R2 count unchanged", cc(1), 16);
      do_halt();
      chk(cc(1) == 0, "R11 halt empties queue", cc(1), 0);

      for (int n = 0; n < 16; n++) run_write(n);
      for (int n = 0; n < 16; n++) run_read(n);

      // R9: unhandled opcodes are skipped
      b0 = nlog; r0 = n_rep0;
      for (int op = 0; op < 16; op++)
         if (op != 1 && op != 8 && op != 9 && op != 10) load(1'b0, {28'h00000F0, 4'(op)});
      load(1'b0, 32'h0000_0108);
      commit(1'b0, 13);
      go(1'b0);
      wait_idle("R9");
      chk(nlog == b0, "R9 no engine activity", nlog - b0, 0);
      chk(n_rep0 - r0 == 1, "R9 run reaches final report", n_rep0 - r0, 1);

      // R3: only the committed words run
      b0 = nlog; r0 = n_rep0;
      load(1'b0, 32'h0000_0331);
      load(1'b0, 32'h0000_5A19);
      load(1'b0, 32'h0000_0108);
      commit(1'b0, 2);
      go(1'b0);
      wait_idle("R3");
      chk(nlog - b0 == 1 && lg_data[b0] == 8'h5A, "R3 partial commit runs two words",
          nlog - b0, 1);
      chk(n_rep0 - r0 == 0, "R3 uncommitted report skipped", n_rep0 - r0, 0);
      chk(cc(0) == 0, "R3 counts cleared", cc(0), 0);

      // R10: error on second byte
      b0 = nlog; r0 = n_rep0; e0 = n_err;
      err_at = nlog + 1;
      load(1'b0, 32'h0000_0441);
      load(1'b0, 32'h3322_1139);
      load(1'b0, 32'h0000_6629);
      load(1'b0, 32'h0000_0108);
      commit(1'b0, 4);
      go(1'b0);
      wait_idle("R10");
      err_at = -1;
      chk(n_err - e0 == 1, "R10 error event", n_err - e0, 1);
      chk(nlog - b0 == 2, "R10 remaining words not run", nlog - b0, 2);
      chk(n_rep0 - r0 == 0, "R10 no report after error", n_rep0 - r0, 0);
      chk(cc(0) == 0, "R10 queue emptied", cc(0), 0);

      // R12: loads to the running queue are refused
      l0 = n_lerr;
      load(1'b1, 32'h0000_0551);
      load(1'b1, 32'h0000_00FA);
      commit(1'b1, 2);
      go(1'b1);
      repeat (4) @(negedge clk);
      load(1'b1, 32'h0000_0108);
      load(1'b0, 32'h0000_0108);
      @(negedge clk);
      chk(n_lerr - l0 == 1, "R12 load to running queue refused", n_lerr - l0, 1);
      chk(cc(0) == 1, "R12 other queue still loads", cc(0), 1);
      wait_idle("R12");
      chk(cc(1) == 0, "R12 running queue count", cc(1), 0);

      // R11: halt mid-run with data in the buffer
      load(1'b1, 32'h0000_0551);
      load(1'b1, 32'h0000_00CA);
      commit(1'b1, 2);
      go(1'b1);
      repeat (12) @(negedge clk);
      chk(busy == 1'b1, "R11 running before halt", busy, 1);
      do_halt();
      chk(!busy, "R11 halt stops run", busy, 0);
      chk(rb_level == 0, "R11 read buffer emptied", rb_level, 0);
      chk(cc(0) == 0 && cc(1) == 0, "R11 both queues emptied", cur_count, 0);

      chk(n_hold == 0, "R13 request held until done", n_hold, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule